// File: doc/BRIEF.md
# Four-way round-robin parallel ALU array

This block keeps the throughput of a single 16-bit ALU while giving the ALU logic four clock cycles to settle. It does this by using four copies of the ALU. One stream of operand vectors arrives, one vector per clock. A one-hot phase sequencer hands each vector to the next copy in rotation. Each copy therefore captures a new vector only once every four cycles. At the end of its four-cycle window, a copy registers its result. An output multiplexer then picks the copy whose window has just closed and writes that result into a single output register. Results leave in the order the vectors arrived, one per clock, a fixed five cycles after the vector was sampled.

The design uses one clock edge throughout. The four phases are clock enables on a shared clock, not divided, gated or dual-edge clocks. The phase sequencer is a four-state machine. Its states are `PH_CORE0`, `PH_CORE1`, `PH_CORE2` and `PH_CORE3`, with one-hot codes 1000, 0100, 0010 and 0001. On every clock edge it moves PH_CORE0→PH_CORE1→PH_CORE2→PH_CORE3→PH_CORE0. Reset forces `PH_CORE0`. In state `PH_COREk`, copy k loads its input register and registers the result of its previous vector.

Software sees the same interface as a single ALU, plus a valid flag on each side. Cycles with `valid_in` low travel through the array as bubbles.

Top module: `rra_array`

## Requirements
- R1: While `rst_n` is low, `valid_out`, `y_out` and `cout_out` are 0. After reset is released, `valid_out` stays 0 for the first five clock edges, no matter what was in flight before the reset.
- R2: The logic opcodes are 2 AND, 3 OR, 4 XOR, 5 NAND, 6 NOR, 7 XNOR, 8 pass A, 9 pass B and 10 NOT A. Each gives carry 0. Opcode 15 returns 1 when A < B (unsigned) and 0 otherwise, with carry 0.
- R3: The arithmetic opcodes work as follows. 0 gives A+B+cin, with carry = bit 16 of the sum. 1 gives A−B−cin, with carry = 1 when a borrow occurs. 13 gives A+1, with carry on overflow. 14 gives A−1, with carry = 1 when A = 0. 11 gives A<<1, with carry = old bit 15. 12 gives A>>1, with carry = old bit 0.
- R4: A vector sampled at clock edge e appears on `y_out`/`cout_out` right after edge e+5. Back-to-back vectors come out at one per clock, in input order.
- R5: `valid_out` after edge e+5 equals `valid_in` sampled at edge e. Bubbles keep their position in the stream.
- R6: While `valid_out` is low, `y_out` and `cout_out` keep the last valid result (0 after reset).
- R7: Exactly one copy is enabled per cycle, in the order 0,1,2,3,0… starting with copy 0 after reset. Each copy registers its result four edges after loading. The output select follows the copy that loaded on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Marks the present vector as real |
| a_in | input | DATA_W | Operand A |
| b_in | input | DATA_W | Operand B |
| op_in | input | 4 | Opcode (see R2, R3) |
| cin_in | input | 1 | Carry/borrow in for opcodes 0 and 1 |
| valid_out | output | 1 | Marks `y_out`/`cout_out` as a fresh result |
| y_out | output | DATA_W | Result |
| cout_out | output | 1 | Carry, borrow or shifted-out bit |

## Verification
The bench first streams vectors at full rate and then with random bubbles. It checks every output cycle against a delayed reference, so a select that pointed one copy off, or a latency off by one, shows up as results that are shuffled or repeated. Directed vectors cover carry out of 0xFFFF, a borrow from 0, a borrow with carry in, the shift-out bits, and decrementing zero. A wrong carry convention fails on these. The bench also resets the array in the middle of a stream. A design whose copies kept stale valid flags would then emit results before five edges had passed. During bubbles, the output must not move; a design that loaded the output register on every cycle would fail there.

// File: rtl/rra_pkg.sv
package rra_pkg;

    localparam int RR_CORES   = 4;
    localparam int RR_SEL_W   = $clog2(RR_CORES);
    localparam int RR_LATENCY = RR_CORES + 1;
    localparam int RR_OP_W    = 4;

    typedef enum logic [RR_OP_W-1:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_OR    = 4'd3,
        OP_XOR   = 4'd4,
        OP_NAND  = 4'd5,
        OP_NOR   = 4'd6,
        OP_XNOR  = 4'd7,
        OP_PASSA = 4'd8,
        OP_PASSB = 4'd9,
        OP_NOTA  = 4'd10,
        OP_SHL   = 4'd11,
        OP_SHR   = 4'd12,
        OP_INC   = 4'd13,
        OP_DEC   = 4'd14,
        OP_LTU   = 4'd15
    } rra_op_e;

    typedef enum logic [RR_CORES-1:0] {
        PH_CORE0 = 4'b1000,
        PH_CORE1 = 4'b0100,
        PH_CORE2 = 4'b0010,
        PH_CORE3 = 4'b0001
    } rra_phase_e;

endpackage

// File: rtl/rra_phase_ring.sv
module rra_phase_ring
    import rra_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    output logic [RR_CORES-1:0] load_en,
    output logic [RR_SEL_W-1:0] load_idx
);

    rra_phase_e state_q;
    rra_phase_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_CORE0;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state rotation
    always_comb begin
        state_d = PH_CORE0;
        unique case (state_q)
            PH_CORE0: state_d = PH_CORE1;
            PH_CORE1: state_d = PH_CORE2;
            PH_CORE2: state_d = PH_CORE3;
            PH_CORE3: state_d = PH_CORE0;
            default:  state_d = PH_CORE0;
        endcase
    end

    // per-copy enables and index of the loading copy
    always_comb begin
        load_en  = '0;
        load_idx = '0;
        unique case (state_q)
            PH_CORE0: begin load_en = 4'b0001; load_idx = 2'd0; end
            PH_CORE1: begin load_en = 4'b0010; load_idx = 2'd1; end
            PH_CORE2: begin load_en = 4'b0100; load_idx = 2'd2; end
            PH_CORE3: begin load_en = 4'b1000; load_idx = 2'd3; end
            default:  begin load_en = '0;      load_idx = '0;   end
        endcase
    end

endmodule

// File: rtl/rra_alu_core.sv
module rra_alu_core
    import rra_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    input  logic [RR_OP_W-1:0] op,
    input  logic               cin,
    output logic [DATA_W-1:0]  y,
    output logic               cout
);

    localparam logic [DATA_W:0] ONE_W = {{DATA_W{1'b0}}, 1'b1};

    logic [DATA_W:0] wide;
    logic [DATA_W:0] cin_w;

    assign cin_w = {{DATA_W{1'b0}}, cin};

    always_comb begin
        y    = '0;
        cout = 1'b0;
        wide = '0;
        unique case (rra_op_e'(op))
            OP_ADD: begin
                wide = {1'b0, a} + {1'b0, b} + cin_w;
                y    = wide[DATA_W-1:0];
                cout = wide[DATA_W];
            end
            OP_SUB: begin
                wide = {1'b0, a} - {1'b0, b} - cin_w;
                y    = wide[DATA_W-1:0];
                cout = wide[DATA_W];
            end
            OP_AND:   y = a & b;
            OP_OR:    y = a | b;
            OP_XOR:   y = a ^ b;
            OP_NAND:  y = ~(a & b);
            OP_NOR:   y = ~(a | b);
            OP_XNOR:  y = ~(a ^ b);
            OP_PASSA: y = a;
            OP_PASSB: y = b;
            OP_NOTA:  y = ~a;
            OP_SHL: begin
                y    = {a[DATA_W-2:0], 1'b0};
                cout = a[DATA_W-1];
            end
            OP_SHR: begin
                y    = {1'b0, a[DATA_W-1:1]};
                cout = a[0];
            end
            OP_INC: begin
                wide = {1'b0, a} + ONE_W;
                y    = wide[DATA_W-1:0];
                cout = wide[DATA_W];
            end
            OP_DEC: begin
                wide = {1'b0, a} - ONE_W;
                y    = wide[DATA_W-1:0];
                cout = wide[DATA_W];
            end
            OP_LTU:   y = {{(DATA_W-1){1'b0}}, (a < b)};
            default: begin
                y    = '0;
                cout = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rra_core_slot.sv
module rra_core_slot
    import rra_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               vin,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    input  logic [RR_OP_W-1:0] op,
    input  logic               cin,
    output logic [DATA_W-1:0]  res_y,
    output logic               res_c,
    output logic               res_v
);

    logic [DATA_W-1:0]  in_a;
    logic [DATA_W-1:0]  in_b;
    logic [RR_OP_W-1:0] in_op;
    logic               in_cin;
    logic               in_v;
    logic [DATA_W-1:0]  alu_y;
    logic               alu_c;

    rra_alu_core #(.DATA_W(DATA_W)) u_alu (
        .a    (in_a),
        .b    (in_b),
        .op   (in_op),
        .cin  (in_cin),
        .y    (alu_y),
        .cout (alu_c)
    );

    // On its phase the copy closes the previous window and opens the next.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_a   <= '0;
            in_b   <= '0;
            in_op  <= '0;
            in_cin <= 1'b0;
            in_v   <= 1'b0;
            res_y  <= '0;
            res_c  <= 1'b0;
            res_v  <= 1'b0;
        end else if (load) begin
            res_y  <= alu_y;
            res_c  <= alu_c;
            res_v  <= in_v;
            in_a   <= a;
            in_b   <= b;
            in_op  <= op;
            in_cin <= cin;
            in_v   <= vin;
        end
    end

endmodule

// File: rtl/rra_out_stage.sv
module rra_out_stage
    import rra_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [RR_SEL_W-1:0]              sel_d,
    input  logic [RR_CORES-1:0][DATA_W-1:0]  res_y,
    input  logic [RR_CORES-1:0]              res_c,
    input  logic [RR_CORES-1:0]              res_v,
    output logic [RR_SEL_W-1:0]              sel_q,
    output logic                             valid_out,
    output logic [DATA_W-1:0]                y_out,
    output logic                             cout_out
);

    logic [DATA_W-1:0] pick_y;
    logic              pick_c;
    logic              pick_v;

    assign pick_y = res_y[sel_q];
    assign pick_c = res_c[sel_q];
    assign pick_v = res_v[sel_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= '0;
            valid_out <= 1'b0;
            y_out     <= '0;
            cout_out  <= 1'b0;
        end else begin
            sel_q     <= sel_d;
            valid_out <= pick_v;
            if (pick_v) begin
                y_out    <= pick_y;
                cout_out <= pick_c;
            end
        end
    end

endmodule

// File: rtl/rra_array.sv
module rra_array
    import rra_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_in,
    input  logic [DATA_W-1:0]  a_in,
    input  logic [DATA_W-1:0]  b_in,
    input  logic [RR_OP_W-1:0] op_in,
    input  logic               cin_in,
    output logic               valid_out,
    output logic [DATA_W-1:0]  y_out,
    output logic               cout_out
);

    logic [RR_CORES-1:0]             phase_en;
    logic [RR_SEL_W-1:0]             phase_idx;
    logic [RR_SEL_W-1:0]             sel_q;
    logic [RR_CORES-1:0][DATA_W-1:0] res_y;
    logic [RR_CORES-1:0]             res_c;
    logic [RR_CORES-1:0]             res_v;

    rra_phase_ring u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (phase_en),
        .load_idx (phase_idx)
    );

    for (genvar k = 0; k < RR_CORES; k++) begin : g_slot
        rra_core_slot #(.DATA_W(DATA_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (phase_en[k]),
            .vin   (valid_in),
            .a     (a_in),
            .b     (b_in),
            .op    (op_in),
            .cin   (cin_in),
            .res_y (res_y[k]),
            .res_c (res_c[k]),
            .res_v (res_v[k])
        );
    end

    rra_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_d     (phase_idx),
        .res_y     (res_y),
        .res_c     (res_c),
        .res_v     (res_v),
        .sel_q     (sel_q),
        .valid_out (valid_out),
        .y_out     (y_out),
        .cout_out  (cout_out)
    );

endmodule

// File: rtl/rra_array_chk.sv
module rra_array_chk
    import rra_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                valid_in,
    input logic                valid_out,
    input logic [DATA_W-1:0]   y_out,
    input logic [RR_CORES-1:0] phase_en,
    input logic [RR_SEL_W-1:0] sel_q
);

    logic                  armed;
    logic [RR_LATENCY:0]   vpipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            vpipe <= '0;
        end else begin
            armed <= 1'b1;
            vpipe <= {vpipe[RR_LATENCY-1:0], valid_in};
        end
    end

    // R7
    ring_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_en) == 1);

    // R7
    ring_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (phase_en == {$past(phase_en[RR_CORES-2:0]), $past(phase_en[RR_CORES-1])}));

    // R7
    sel_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ($past(phase_en) == (RR_CORES'(1) << sel_q)));

    // R5
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out == vpipe[RR_LATENCY]);

    // R6
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !valid_out) |-> $stable(y_out));

endmodule

bind rra_array rra_array_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .valid_out (valid_out),
    .y_out     (y_out),
    .phase_en  (phase_en),
    .sel_q     (sel_q)
);

// File: tb/tb_rra_array.sv
module tb_rra_array;

    localparam int W   = 16;
    localparam int LAT = 5;
    localparam int HN  = 2048;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_in = 1'b0;
    logic [W-1:0]  a_in = '0;
    logic [W-1:0]  b_in = '0;
    logic [3:0]    op_in = '0;
    logic          cin_in = 1'b0;
    logic          valid_out;
    logic [W-1:0]  y_out;
    logic          cout_out;

    always #2 clk = ~clk;

    rra_array #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .a_in(a_in), .b_in(b_in),
        .op_in(op_in), .cin_in(cin_in), .valid_out(valid_out), .y_out(y_out),
        .cout_out(cout_out)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int n = 0;
    bit done = 0;
    logic         hv  [HN];
    logic [W-1:0] ha  [HN];
    logic [W-1:0] hb  [HN];
    logic [3:0]   hop [HN];
    logic         hc  [HN];
    logic [W-1:0] last_y = '0;
    logic         last_c = 1'b0;

    // expected {carry, result} from the opcode table in R2 and R3
    function automatic logic [W:0] ref_alu(input logic [3:0] op, input logic [W-1:0] a,
                                           input logic [W-1:0] b, input logic ci);
        int ai = int'(a);
        int bi = int'(b);
        int cn = int'(ci);
        int r;
        logic [W-1:0] y = '0;
        logic c = 1'b0;
        case (op)
            4'd0:  begin r = ai + bi + cn; y = r[15:0]; c = r[16]; end
            4'd1:  begin r = ai - bi - cn; y = r[15:0]; c = (r < 0); end
            4'd2:  y = a & b;
            4'd3:  y = a | b;
            4'd4:  y = a ^ b;
            4'd5:  y = ~(a & b);
            4'd6:  y = ~(a | b);
            4'd7:  y = ~(a ^ b);
            4'd8:  y = a;
            4'd9:  y = b;
            4'd10: y = ~a;
            4'd11: begin y = a << 1; c = a[15]; end
            4'd12: begin y = a >> 1; c = a[0]; end
            4'd13: begin r = ai + 1; y = r[15:0]; c = r[16]; end
            4'd14: begin r = ai - 1; y = r[15:0]; c = (r < 0); end
            default: y = (ai < bi) ? 16'd1 : 16'd0;
        endcase
        return {c, y};
    endfunction

    function automatic bit is_arith(input logic [3:0] op);
        return (op == 4'd0 || op == 4'd1 || op == 4'd11 || op == 4'd12 ||
                op == 4'd13 || op == 4'd14);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [3:0] op, input logic ci);
        int e;
        logic ev;
        logic [W:0] r;
        valid_in = v; a_in = a; b_in = b; op_in = op; cin_in = ci;
        @(posedge clk);
        e = n;
        hv[e] = v; ha[e] = a; hb[e] = b; hop[e] = op; hc[e] = ci;
        n++;
        @(negedge clk);
        if (e >= LAT) begin
            ev = hv[e-LAT];
            check("R5", "valid_out", 32'(valid_out), 32'(ev));
            if (ev) begin
                r = ref_alu(hop[e-LAT], ha[e-LAT], hb[e-LAT], hc[e-LAT]);
                if (is_arith(hop[e-LAT])) begin
                    check("R3 R4 R7", "y_out", 32'(y_out), 32'(r[W-1:0]));
                    check("R3 R4 R7", "cout_out", 32'(cout_out), 32'(r[W]));
                end else begin
                    check("R2 R4 R7", "y_out", 32'(y_out), 32'(r[W-1:0]));
                    check("R2 R4 R7", "cout_out", 32'(cout_out), 32'(r[W]));
                end
                last_y = r[W-1:0];
                last_c = r[W];
            end else begin
                check("R6", "held y_out", 32'(y_out), 32'(last_y));
                check("R6", "held cout_out", 32'(cout_out), 32'(last_c));
            end
        end else begin
            check("R1", "valid_out during fill", 32'(valid_out), 32'd0);
            check("R6", "held y_out during fill", 32'(y_out), 32'(last_y));
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        valid_in = 1'b0; a_in = '0; b_in = '0; op_in = '0; cin_in = 1'b0;
        #1;
        check("R1", "valid_out in reset", 32'(valid_out), 32'd0);
        check("R1", "y_out in reset", 32'(y_out), 32'd0);
        check("R1", "cout_out in reset", 32'(cout_out), 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        last_y = '0;
        last_c = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < LAT + 2; i++) step(1'b0, 16'hDEAD, 16'hBEEF, 4'd0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R4 watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd1207);
        @(negedge clk);
        apply_reset();

        // every opcode once, full rate
        for (int op = 0; op < 16; op++)
            step(1'b1, 16'hA5C3, 16'h3C5A, 4'(op), op[0]);

        // carry, borrow and shift corners
        step(1'b1, 16'hFFFF, 16'h0001, 4'd0, 1'b0);
        step(1'b1, 16'hFFFF, 16'h0000, 4'd0, 1'b1);
        step(1'b1, 16'h0000, 16'h0001, 4'd1, 1'b0);
        step(1'b1, 16'h0000, 16'hFFFF, 4'd1, 1'b1);
        step(1'b1, 16'h0005, 16'h0005, 4'd1, 1'b0);
        step(1'b1, 16'h8000, 16'h0000, 4'd11, 1'b0);
        step(1'b1, 16'h0001, 16'h0000, 4'd12, 1'b0);
        step(1'b1, 16'hFFFF, 16'h0000, 4'd13, 1'b0);
        step(1'b1, 16'h0000, 16'h0000, 4'd14, 1'b0);
        step(1'b1, 16'hFFFF, 16'h0001, 4'd4, 1'b0);
        step(1'b1, 16'h0003, 16'h0004, 4'd15, 1'b0);
        step(1'b1, 16'h0004, 16'h0003, 4'd15, 1'b0);
        step(1'b1, 16'h1234, 16'h1234, 4'd15, 1'b0);
        drain();

        // back-to-back random stream
        for (int i = 0; i < 300; i++)
            step(1'b1, 16'($urandom), 16'($urandom), 4'($urandom), 1'($urandom));
        drain();

        // random stream with bubbles
        for (int i = 0; i < 300; i++)
            step(($urandom % 10) < 6, 16'($urandom), 16'($urandom),
                 4'($urandom), 1'($urandom));

        // reset in mid-stream, then restart
        for (int i = 0; i < 3; i++)
            step(1'b1, 16'($urandom), 16'($urandom), 4'($urandom), 1'($urandom));
        @(negedge clk);
        apply_reset();
        for (int i = 0; i < 40; i++)
            step(1'b1, 16'($urandom), 16'($urandom), 4'($urandom), 1'($urandom));
        drain();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule